// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the power-on bring-up and the refresh upkeep of an asynchronous DRAM. Leaving reset, it waits out a power-on pause, then asks the access controller for the bus and runs a burst of wake-up strobe cycles. After that it declares the memory usable and raises one refresh request per refresh interval. Every strobe cycle it generates is a CAS-before-RAS refresh. The DRAM takes the row from its own internal counter, so the sequencer never drives the address or data bus.

Bus ownership uses a request/grant pair. While the grant is withheld, elapsed intervals build up in a backlog counter. A bounded number of refreshes can be postponed in this way, and once the grant returns they are carried out back to back. If one more interval expires while the backlog is full, the retention guarantee is lost. Ready then drops and the whole wake-up burst is run again. All times are parameters counted in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, both strobes are high, the bus request is low and ready is low.
- R2: After reset, the bus request stays low and the strobes stay high for PAUSE_CYC clock cycles. The request rises in the cycle after the PAUSE_CYC-th clock edge.
- R3: After the pause, exactly WAKE_CNT strobe cycles run, each starting one cycle after the previous one ends. Ready rises in the cycle after the last wake-up cycle finishes, with both strobes high.
- R4: Each strobe cycle is CAS-before-RAS. CAS falls while RAS is high, RAS falls CSR_CYC cycles later, and CAS rises CHR_CYC cycles after RAS fell.
- R5: RAS stays low for exactly RAS_LOW_CYC cycles, and both strobes stay high for at least PRECH_CYC cycles before the next CAS fall.
- R6: A strobe cycle starts only in the cycle after the grant was sampled high together with a pending request.
- R7: While ready, a refresh becomes pending every INTERVAL_CYC cycles. With the grant held high, its strobe cycle starts two cycles after the interval counter expires.
- R8: With the grant low, up to MAX_PEND expired intervals are held without loss while ready stays high. When the grant returns, the backlog runs as back-to-back cycles.
- R9: An interval that expires while MAX_PEND refreshes are already pending drops ready in the next cycle and clears the backlog. It then reruns the full WAKE_CNT wake-up burst, and ready rises again after it.
- R10: The bus request is high during every cycle in which either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_grant_i | input | 1 | Bus granted by the access controller |
| bus_req_o | output | 1 | Sequencer wants or holds the bus |
| ras_n_o | output | 1 | Row strobe to the DRAM, active low |
| cas_n_o | output | 1 | Column strobe to the DRAM, active low |
| mem_ready_o | output | 1 | Memory is initialised and its contents are being retained |

## Verification
The checks assume the access controller follows the handshake. The grant may be withdrawn only while no strobe cycle is in progress, and once given it stays high until the request's current cycle has completed. The stimulus meets this by changing the grant only at cycle counts where the schedule computed for it shows the sequencer idle. It holds the grant low over several refresh intervals to build a backlog, and once over nine intervals to force the overflow recovery. A scoreboard queue holds every expected CAS fall time. For each cycle it observes, the monitor measures setup, hold, RAS width and precharge.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [1:0] {
    ST_PAUSE = 2'd0,
    ST_WAKE  = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/drs_timer.sv
module drs_timer #(
  parameter int PAUSE_CYC    = 25000,
  parameter int INTERVAL_CYC = 1950
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sel_pause_i,
  output logic hit_o
);
  localparam int MAXC = (PAUSE_CYC > INTERVAL_CYC) ? PAUSE_CYC : INTERVAL_CYC;
  localparam int W    = $clog2(MAXC + 1);
  localparam logic [W-1:0] LIM_PAUSE = W'(PAUSE_CYC - 1);
  localparam logic [W-1:0] LIM_INTV  = W'(INTERVAL_CYC - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;

  assign lim   = sel_pause_i ? LIM_PAUSE : LIM_INTV;
  assign hit_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || hit_o)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/drs_pending.sv
module drs_pending #(
  parameter int MAX_PEND = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic any_o,
  output logic ovf_o
);
  localparam int W = $clog2(MAX_PEND + 1);
  localparam logic [W-1:0] FULL = W'(MAX_PEND);

  logic [W-1:0] cnt_q;

  assign any_o = (cnt_q != '0);
  // a tick arriving with a full backlog and nothing draining loses a refresh
  assign ovf_o = inc_i && !dec_i && (cnt_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || ovf_o)    cnt_q <= '0;
    else if (inc_i && !dec_i)   cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/drs_cbr_engine.sv
module drs_cbr_engine #(
  parameter int CSR_CYC     = 2,
  parameter int CHR_CYC     = 2,
  parameter int RAS_LOW_CYC = 7,
  parameter int PRECH_CYC   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int TOTAL = CSR_CYC + RAS_LOW_CYC + PRECH_CYC;
  localparam int W     = $clog2(TOTAL + 1);
  localparam logic [W-1:0] K_LAST    = W'(TOTAL - 1);
  localparam logic [W-1:0] K_RAS_ON  = W'(CSR_CYC);
  localparam logic [W-1:0] K_CAS_END = W'(CSR_CYC + CHR_CYC);
  localparam logic [W-1:0] K_RAS_END = W'(CSR_CYC + RAS_LOW_CYC);

  logic [W-1:0] ph_q;
  logic         busy_q;

  assign busy_o  = busy_q;
  assign done_o  = busy_q && (ph_q == K_LAST);
  assign cas_n_o = !(busy_q && (ph_q < K_CAS_END));
  assign ras_n_o = !(busy_q && (ph_q >= K_RAS_ON) && (ph_q < K_RAS_END));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      ph_q   <= '0;
    end else if (busy_q) begin
      if (ph_q == K_LAST) begin
        busy_q <= 1'b0;
        ph_q   <= '0;
      end else begin
        ph_q   <= ph_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drs_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int INTERVAL_CYC = 1950,
  parameter int WAKE_CNT     = 8,
  parameter int MAX_PEND     = 8,
  parameter int CSR_CYC      = 2,
  parameter int CHR_CYC      = 2,
  parameter int RAS_LOW_CYC  = 7,
  parameter int PRECH_CYC    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_grant_i,
  output logic bus_req_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic mem_ready_o
);
  localparam int WW = $clog2(WAKE_CNT + 1);
  localparam logic [WW-1:0] WAKE_ALL = WW'(WAKE_CNT);

  seq_state_e    state_q;
  logic [WW-1:0] wake_cnt_q;
  logic          tmr_hit, pend_any, pend_ovf;
  logic          busy, done, go, in_run, in_wake;

  assign in_run  = (state_q == ST_RUN);
  assign in_wake = (state_q == ST_WAKE);

  assign bus_req_o   = busy || in_wake || (in_run && pend_any);
  assign go          = bus_grant_i && !busy &&
                       ((in_wake && wake_cnt_q != WAKE_ALL) || (in_run && pend_any));
  assign mem_ready_o = in_run;

  drs_timer #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (!in_wake),
    .sel_pause_i(state_q == ST_PAUSE),
    .hit_o      (tmr_hit)
  );

  drs_pending #(
    .MAX_PEND(MAX_PEND)
  ) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!in_run),
    .inc_i (tmr_hit && in_run),
    .dec_i (go && in_run),
    .any_o (pend_any),
    .ovf_o (pend_ovf)
  );

  drs_cbr_engine #(
    .CSR_CYC    (CSR_CYC),
    .CHR_CYC    (CHR_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .PRECH_CYC  (PRECH_CYC)
  ) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(go),
    .busy_o (busy),
    .done_o (done),
    .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PAUSE;
      wake_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_PAUSE: if (tmr_hit) begin
          state_q    <= ST_WAKE;
          wake_cnt_q <= '0;
        end
        ST_WAKE: begin
          if (go) wake_cnt_q <= wake_cnt_q + 1'b1;
          if (done && wake_cnt_q == WAKE_ALL) state_q <= ST_RUN;
        end
        ST_RUN: if (pend_ovf) begin
          state_q    <= ST_WAKE;
          wake_cnt_q <= '0;
        end
        default: state_q <= ST_PAUSE;
      endcase
    end
  end
endmodule

// File: rtl/drs_seq_chk.sv
module drs_seq_chk #(
  parameter int RAS_LOW_CYC = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_grant_i,
  input logic bus_req_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic mem_ready_o
);
  logic [15:0] ras_lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ras_lo_cnt <= '0;
    else if (!ras_n_o) ras_lo_cnt <= ras_lo_cnt + 1'b1;
    else               ras_lo_cnt <= '0;
  end

  p_start_granted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> $past(bus_grant_i));

  p_cas_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> ras_n_o);

  p_cas_setup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && !$past(cas_n_o)));

  p_ras_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (ras_lo_cnt == 16'(RAS_LOW_CYC)));

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> bus_req_o);

  p_ready_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ready_o) |-> (ras_n_o && cas_n_o));

  p_ready_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ready_o) |-> bus_req_o);
endmodule

bind dram_refresh_seq drs_seq_chk #(.RAS_LOW_CYC(RAS_LOW_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_grant_i(bus_grant_i),
  .bus_req_o  (bus_req_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .mem_ready_o(mem_ready_o)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int PAUSE = 20;
  localparam int INTV  = 40;
  localparam int WAKE  = 8;
  localparam int MAXP  = 8;
  localparam int CSR   = 2;
  localparam int CHR   = 2;
  localparam int RASL  = 5;
  localparam int PRE   = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic grant = 1'b0;
  logic req, ras_n, cas_n, ready;

  always #4 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTV), .WAKE_CNT(WAKE), .MAX_PEND(MAXP),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_LOW_CYC(RASL), .PRECH_CYC(PRE)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_grant_i(grant), .bus_req_o(req),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .mem_ready_o(ready)
  );

  int cyc = 0;
  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int exp_q[$];
  string tag_q[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at cyc %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic push(int t, string tag);
    exp_q.push_back(t);
    tag_q.push_back(tag);
  endtask

  task automatic wait_cyc(int n);
    do @(negedge clk); while (cyc < n);
  endtask

  // monitor: pops expected CAS fall times and measures each strobe cycle
  bit prev_ras = 1'b1;
  bit prev_cas = 1'b1;
  int t0 = 0;
  int last_rr = -100;
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      if (prev_cas && !cas_n) begin
        t0 = cyc;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected strobe cycle start", cyc, -1);
        end else begin
          int e;
          string tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(cyc == e, tg, "CAS fall time", cyc, e);
        end
        check(grant == 1'b1, "R6", "grant at cycle start", int'(grant), 1);
        check(ras_n == 1'b1, "R4", "RAS high at CAS fall", int'(ras_n), 1);
        check(cyc - last_rr >= PRE, "R5", "precharge length", cyc - last_rr, PRE);
      end
      if (prev_ras && !ras_n) check(cyc == t0 + CSR, "R4", "RAS fall time", cyc, t0 + CSR);
      if (!prev_cas && cas_n) check(cyc == t0 + CSR + CHR, "R4", "CAS rise time", cyc, t0 + CSR + CHR);
      if (!prev_ras && ras_n) begin
        check(cyc == t0 + CSR + RASL, "R5", "RAS rise time", cyc, t0 + CSR + RASL);
        last_rr = cyc;
      end
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  initial begin
    for (int i = 0; i < WAKE; i++) push(PAUSE + 1 + 11 * i, "R3");
    push(149, "R7");
    push(189, "R7");
    push(229, "R7");
    for (int i = 0; i < 6; i++) push(441 + 11 * i, "R8");
    push(509, "R7");
    for (int i = 0; i < WAKE; i++) push(881 + 11 * i, "R9");
    push(1009, "R7");

    grant = 1'b1;
    #1;
    check(ras_n == 1'b1, "R1", "RAS in reset", int'(ras_n), 1);
    check(cas_n == 1'b1, "R1", "CAS in reset", int'(cas_n), 1);
    check(req == 1'b0, "R1", "request in reset", int'(req), 0);
    check(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    wait_cyc(PAUSE - 1);
    check(req == 1'b0, "R2", "request at end of pause", int'(req), 0);
    wait_cyc(PAUSE);
    check(req == 1'b1, "R2", "request after pause", int'(req), 1);

    wait_cyc(107);
    check(ready == 1'b0, "R3", "ready before last wake cycle ends", int'(ready), 0);
    wait_cyc(108);
    check(ready == 1'b1, "R3", "ready after wake burst", int'(ready), 1);

    wait_cyc(240);
    grant = 1'b0;
    wait_cyc(439);
    check(req == 1'b1, "R8", "request with backlog", int'(req), 1);
    check(ready == 1'b1, "R8", "ready kept with backlog", int'(ready), 1);
    wait_cyc(440);
    grant = 1'b1;

    wait_cyc(520);
    grant = 1'b0;
    wait_cyc(867);
    check(ready == 1'b1, "R8", "ready with full backlog", int'(ready), 1);
    wait_cyc(868);
    check(ready == 1'b0, "R9", "ready after overflow", int'(ready), 0);
    check(req == 1'b1, "R9", "request for rerun wake", int'(req), 1);
    wait_cyc(880);
    grant = 1'b1;
    wait_cyc(967);
    check(ready == 1'b0, "R9", "ready during rerun wake", int'(ready), 0);
    wait_cyc(968);
    check(ready == 1'b1, "R9", "ready after rerun wake", int'(ready), 1);

    wait_cyc(1030);
    check(exp_q.size() == 0, "R7", "cycles left unseen", exp_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected=%0d", cyc, 1030);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule